// File: doc/BRIEF.md
# Coprocessor Run-State Sequencer

This block chooses, one step at a time, what a small coprocessor spends its cycles on. A set of control flags feeds a fixed priority scheme, and each step grants exactly one activity. The activities are: idling because the core is locked, a timed or endless wait, a program-page fill, a DMA transfer, idling because the core is halted, or fetching and executing an instruction. The fill engine, the DMA datapath and the instruction decoder sit outside this block. The block reaches each of them through a start pulse and a done strobe.

The block also holds a single deferred memory access. When the host launches an access, the block stores an address, a direction and a cycle budget. The budget counts down once per clock. When it runs out, the access completes in one cycle: a read loads the memory data register, and a write presents that register to memory. Two status outputs are derived from the flags. Busy shows that background work is outstanding. Running shows that the core is either busy or not halted.

The sequencer is a state machine with six named states:
- `ST_PICK` evaluates the priorities and consumes the step for the lock, halt and endless-wait idles, and for the fetch.
- `ST_SUSPEND` counts down the rest of a timed wait.
- `ST_FILL` and `ST_DMA` each wait for their done strobe.
- `ST_DISPATCH` issues the start pulse to the instruction executor.
- `ST_EXEC` waits for the executor to finish.

All transitions return to `ST_PICK`.

Top module: `run_seq`

## Requirements
- R1: After reset every flag, counter and the data register are zero. `grant` shows fetch (code 5), `busy` is 0, `running` is 1, and no memory strobe is active.
- R2: In `ST_PICK` the grant follows a fixed order: lock (code 1) first, then suspend (2), fill (3), DMA (4), halt (0), and otherwise fetch (5). A lower-ranked pending request is never started while a higher one holds.
- R3: `lock_set` and `halt_set` pulses set sticky flags that only reset clears. Each step taken under them idles for one cycle in `ST_PICK`.
- R4: A suspend loaded with length 0 grants suspend (code 2) on every cycle and never ends on its own.
- R5: A suspend loaded with length N > 0 grants suspend for exactly N consecutive cycles, starting at the pick cycle, and then clears itself. A `susp_set` that arrives while a suspend is loaded is ignored.
- R6: A fill or DMA grant raises its start pulse for one cycle in the pick cycle. The grant then holds (code 3 or 4) until the matching done strobe arrives, and that strobe clears the request. A done strobe outside its own state is ignored. A set pulse that coincides with the clearing done wins.
- R7: A fetch takes one pick cycle (code 5). The next cycle is `ST_DISPATCH`, which raises `exec_start` with grant code 6. The grant stays at 6 until `exec_done`, and the next cycle picks again.
- R8: A `bus_launch` while no access is outstanding captures the address, the direction and the budget P. The access completes on the max(P,1)-th cycle after the capturing edge, with a single one-cycle strobe that carries the stored address. A launch while an access is outstanding is ignored.
- R9: A read completion loads `mdr` from `mem_rdata` and takes precedence over `mdr_load`. A write completion presents `mdr` on `mem_wdata`. Otherwise `mdr_load` writes `mdr_din` into `mdr`.
- R10: `busy` is high while a fill request, a DMA request or a bus access is pending. `running` is `busy` OR not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_set | input | 1 | Pulse that sets the sticky lock flag |
| halt_set | input | 1 | Pulse that sets the sticky halt flag |
| susp_set | input | 1 | Pulse that loads a suspend request |
| susp_cycles | input | SUSP_W | Suspend length; 0 means endless |
| fill_set | input | 1 | Pulse that raises a page-fill request |
| dma_set | input | 1 | Pulse that raises a DMA request |
| fill_start | output | 1 | One-cycle start to the fill engine |
| fill_done | input | 1 | Fill engine finished |
| dma_start | output | 1 | One-cycle start to the DMA datapath |
| dma_done | input | 1 | DMA datapath finished |
| exec_start | output | 1 | One-cycle start to the instruction executor |
| exec_done | input | 1 | Instruction executor finished |
| grant | output | 3 | Activity of this cycle: 0 halt, 1 lock, 2 suspend, 3 fill, 4 DMA, 5 fetch, 6 execute |
| bus_launch | input | 1 | Start a deferred memory access |
| bus_write | input | 1 | Direction of the launched access: 1 write, 0 read |
| bus_addr | input | ADDR_W | Address of the launched access |
| bus_cycles | input | PEND_W | Cycle budget of the launched access |
| mdr_load | input | 1 | Write `mdr_din` into the data register |
| mdr_din | input | DATA_W | Data for `mdr_load` |
| mem_rd | output | 1 | Read strobe in the completion cycle |
| mem_wr | output | 1 | Write strobe in the completion cycle |
| mem_addr | output | ADDR_W | Stored access address |
| mem_wdata | output | DATA_W | Write data (the data register) |
| mem_rdata | input | DATA_W | Read data, valid in the cycle `mem_rd` is high |
| mdr | output | DATA_W | Memory data register |
| busy | output | 1 | Background work pending |
| running | output | 1 | Busy or not halted |

## Verification
The assertions rely on four assumptions about the neighbours:
- Set pulses last one cycle.
- `mem_rdata` is valid in the cycle that `mem_rd` is high.
- The fill, DMA and execute units return their done strobe no earlier than the cycle after their start pulse.
- The executor is only ever started from the dispatch state.

The bench's responders wait at least one cycle before answering each start pulse. The bench drives every host input for exactly one cycle on the falling edge. It also injects a stray fill done only while a DMA transfer holds the grant, which is the case the ignore rule covers.

// File: rtl/run_seq_pkg.sv
package run_seq_pkg;

    // Activity reported on the grant output each cycle.
    typedef enum logic [2:0] {
        GR_HALT    = 3'd0,
        GR_LOCK    = 3'd1,
        GR_SUSPEND = 3'd2,
        GR_FILL    = 3'd3,
        GR_DMA     = 3'd4,
        GR_FETCH   = 3'd5,
        GR_EXEC    = 3'd6
    } grant_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_PICK,
        ST_SUSPEND,
        ST_FILL,
        ST_DMA,
        ST_DISPATCH,
        ST_EXEC
    } state_t;

endpackage

// File: rtl/run_seq_picker.sv
module run_seq_picker
    import run_seq_pkg::*;
(
    input  logic   lock_q,
    input  logic   susp_en_q,
    input  logic   fill_q,
    input  logic   dma_q,
    input  logic   halt_q,
    output grant_t pick
);

    // Fixed ranking: the first flag that holds wins the step.
    always_comb begin
        if (lock_q)         pick = GR_LOCK;
        else if (susp_en_q) pick = GR_SUSPEND;
        else if (fill_q)    pick = GR_FILL;
        else if (dma_q)     pick = GR_DMA;
        else if (halt_q)    pick = GR_HALT;
        else                pick = GR_FETCH;
    end

endmodule

// File: rtl/run_seq_busunit.sv
module run_seq_busunit #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_wr,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [PEND_W-1:0] launch_cycles,
    input  logic              mdr_load,
    input  logic [DATA_W-1:0] mdr_din,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mdr,
    output logic              active
);

    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    logic              active_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PEND_W-1:0] pend_q;
    logic [DATA_W-1:0] mdr_q;
    logic              finish;

    // The access finishes once the remaining budget is no larger than one cycle.
    assign finish = active_q && !(pend_q > PEND_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            pend_q   <= '0;
        end else if (!active_q) begin
            if (launch) begin
                active_q <= 1'b1;
                wr_q     <= launch_wr;
                addr_q   <= launch_addr;
                pend_q   <= launch_cycles;
            end
        end else if (pend_q > PEND_ONE) begin
            pend_q <= pend_q - PEND_ONE;
        end else begin
            active_q <= 1'b0;
            pend_q   <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               mdr_q <= '0;
        else if (finish && !wr_q) mdr_q <= mem_rdata;
        else if (mdr_load)        mdr_q <= mdr_din;
    end

    assign mem_rd   = finish && !wr_q;
    assign mem_wr   = finish && wr_q;
    assign mem_addr = addr_q;
    assign mdr      = mdr_q;
    assign active   = active_q;

endmodule

// File: rtl/run_seq.sv
module run_seq
    import run_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int SUSP_W = 8,
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_set,
    input  logic              halt_set,
    input  logic              susp_set,
    input  logic [SUSP_W-1:0] susp_cycles,
    input  logic              fill_set,
    input  logic              dma_set,
    output logic              fill_start,
    input  logic              fill_done,
    output logic              dma_start,
    input  logic              dma_done,
    output logic              exec_start,
    input  logic              exec_done,
    output logic [2:0]        grant,
    input  logic              bus_launch,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PEND_W-1:0] bus_cycles,
    input  logic              mdr_load,
    input  logic [DATA_W-1:0] mdr_din,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mdr,
    output logic              busy,
    output logic              running
);

    localparam logic [SUSP_W-1:0] SUSP_ONE = SUSP_W'(1);

    state_t            st_q, st_d;
    logic [SUSP_W-1:0] cnt_q, cnt_d;
    logic              lock_q, halt_q, susp_en_q, fill_q, dma_q;
    logic [SUSP_W-1:0] susp_len_q;
    logic              susp_clr;
    logic              bus_active;
    grant_t            pick, gr;

    run_seq_picker u_picker (
        .lock_q    (lock_q),
        .susp_en_q (susp_en_q),
        .fill_q    (fill_q),
        .dma_q     (dma_q),
        .halt_q    (halt_q),
        .pick      (pick)
    );

    run_seq_busunit #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PEND_W (PEND_W)
    ) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (bus_launch),
        .launch_wr     (bus_write),
        .launch_addr   (bus_addr),
        .launch_cycles (bus_cycles),
        .mdr_load      (mdr_load),
        .mdr_din       (mdr_din),
        .mem_rdata     (mem_rdata),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .mem_addr      (mem_addr),
        .mdr           (mdr),
        .active        (bus_active)
    );

    // Next-state and suspend bookkeeping.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        susp_clr = 1'b0;
        unique case (st_q)
            ST_PICK: begin
                unique case (pick)
                    GR_SUSPEND: begin
                        if (susp_len_q == SUSP_ONE) begin
                            susp_clr = 1'b1;
                        end else if (susp_len_q != '0) begin
                            cnt_d = susp_len_q - SUSP_ONE;
                            st_d  = ST_SUSPEND;
                        end
                    end
                    GR_FILL:  st_d = ST_FILL;
                    GR_DMA:   st_d = ST_DMA;
                    GR_FETCH: st_d = ST_DISPATCH;
                    default:  st_d = ST_PICK;
                endcase
            end
            ST_SUSPEND: begin
                if (cnt_q == SUSP_ONE) begin
                    susp_clr = 1'b1;
                    st_d     = ST_PICK;
                end else begin
                    cnt_d = cnt_q - SUSP_ONE;
                end
            end
            ST_FILL:     if (fill_done) st_d = ST_PICK;
            ST_DMA:      if (dma_done)  st_d = ST_PICK;
            ST_DISPATCH: st_d = ST_EXEC;
            ST_EXEC:     if (exec_done) st_d = ST_PICK;
            default:     st_d = ST_PICK;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_PICK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Control flags: lock and halt are sticky; a set pulse beats a clearing done.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q     <= 1'b0;
            halt_q     <= 1'b0;
            susp_en_q  <= 1'b0;
            susp_len_q <= '0;
            fill_q     <= 1'b0;
            dma_q      <= 1'b0;
        end else begin
            lock_q <= lock_q | lock_set;
            halt_q <= halt_q | halt_set;
            if (susp_set && !susp_en_q) begin
                susp_en_q  <= 1'b1;
                susp_len_q <= susp_cycles;
            end else if (susp_clr) begin
                susp_en_q  <= 1'b0;
                susp_len_q <= '0;
            end
            fill_q <= fill_set | (fill_q & ~((st_q == ST_FILL) & fill_done));
            dma_q  <= dma_set  | (dma_q  & ~((st_q == ST_DMA)  & dma_done));
        end
    end

    // Outputs.
    always_comb begin
        gr         = GR_EXEC;
        fill_start = 1'b0;
        dma_start  = 1'b0;
        exec_start = 1'b0;
        unique case (st_q)
            ST_PICK: begin
                gr         = pick;
                fill_start = (pick == GR_FILL);
                dma_start  = (pick == GR_DMA);
            end
            ST_SUSPEND:  gr = GR_SUSPEND;
            ST_FILL:     gr = GR_FILL;
            ST_DMA:      gr = GR_DMA;
            ST_DISPATCH: begin
                gr         = GR_EXEC;
                exec_start = 1'b1;
            end
            ST_EXEC:     gr = GR_EXEC;
            default:     gr = GR_EXEC;
        endcase
    end

    assign grant     = gr;
    assign mem_wdata = mdr;
    assign busy      = fill_q | dma_q | bus_active;
    assign running   = busy | ~halt_q;

endmodule

// File: rtl/run_seq_chk.sv
module run_seq_chk
    import run_seq_pkg::*;
#(
    parameter int SUSP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input state_t            st,
    input logic [2:0]        grant,
    input logic              fill_start,
    input logic              dma_start,
    input logic              exec_start,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              busy,
    input logic              lock_q,
    input logic              susp_en_q,
    input logic [SUSP_W-1:0] susp_len_q
);

    // R2: a held lock takes every pick cycle
    a_r2_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PICK && lock_q) |-> grant == GR_LOCK);

    // R3: lock never drops without reset
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R4: an endless suspend stays loaded
    a_r4_endless_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_en_q && susp_len_q == '0) |=> susp_en_q);

    // R6: at most one start pulse per cycle
    a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_start, dma_start, exec_start}));

    // R7: a fetch cycle is followed by the dispatch pulse
    a_r7_dispatch_next: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PICK && grant == GR_FETCH) |=> (exec_start && grant == GR_EXEC));

    // R8: strobes are exclusive and never back to back
    a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r8_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

    // R10: a completing access counts as busy
    a_r10_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

endmodule

bind run_seq run_seq_chk #(.SUSP_W(SUSP_W)) u_run_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .grant      (grant),
    .fill_start (fill_start),
    .dma_start  (dma_start),
    .exec_start (exec_start),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .busy       (busy),
    .lock_q     (lock_q),
    .susp_en_q  (susp_en_q),
    .susp_len_q (susp_len_q)
);

// File: tb/test_run_seq.sv
module test_run_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int SW = 8;
    localparam int PW = 8;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_set = 0, halt_set = 0, susp_set = 0, fill_set = 0, dma_set = 0;
    logic [SW-1:0] susp_cycles = '0;
    logic          bus_launch = 0, bus_write = 0, mdr_load = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [PW-1:0] bus_cycles = '0;
    logic [DW-1:0] mdr_din = '0;
    logic          r_fill_done = 0, r_dma_done = 0, r_exec_done = 0, spur_fill = 0;

    logic          fill_start, dma_start, exec_start, fill_done, dma_done, exec_done;
    logic [2:0]    grant;
    logic          mem_rd, mem_wr, busy, running;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, mdr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign fill_done = r_fill_done | spur_fill;
    assign dma_done  = r_dma_done;
    assign exec_done = r_exec_done;
    assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;

    run_seq #(.ADDR_W(AW), .DATA_W(DW), .SUSP_W(SW), .PEND_W(PW)) i_run_seq (
        .clk(clk), .rst_n(rst_n), .lock_set(lock_set), .halt_set(halt_set),
        .susp_set(susp_set), .susp_cycles(susp_cycles), .fill_set(fill_set),
        .dma_set(dma_set), .fill_start(fill_start), .fill_done(fill_done),
        .dma_start(dma_start), .dma_done(dma_done), .exec_start(exec_start),
        .exec_done(exec_done), .grant(grant), .bus_launch(bus_launch),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_cycles(bus_cycles),
        .mdr_load(mdr_load), .mdr_din(mdr_din), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mdr(mdr), .busy(busy), .running(running)
    );

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, m_cnt = 0, m_slen = 0, m_bpend = 0, m_baddr = 0, m_mdr = 0;
    bit m_lock = 0, m_halt = 0, m_sen = 0, m_fill = 0, m_dma = 0, m_bact = 0, m_bwr = 0;

    function automatic int m_pick();
        if (m_lock) return 1;
        if (m_sen)  return 2;
        if (m_fill) return 3;
        if (m_dma)  return 4;
        if (m_halt) return 0;
        return 5;
    endfunction

    function automatic int m_grant();
        case (m_ph)
            0: return m_pick();
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk) begin
        bit sclr, fdone, ddone, bfin;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_slen = 0; m_bpend = 0; m_baddr = 0; m_mdr = 0;
            m_lock = 0; m_halt = 0; m_sen = 0; m_fill = 0; m_dma = 0; m_bact = 0; m_bwr = 0;
        end else begin
            bfin = m_bact && (m_bpend <= 1);
            if (bfin && !m_bwr) m_mdr = (m_baddr & 16'hFFFF) ^ 16'h5A3C;
            else if (mdr_load)  m_mdr = int'(mdr_din);
            if (!m_bact) begin
                if (bus_launch) begin
                    m_bact = 1; m_bwr = bus_write; m_baddr = int'(bus_addr); m_bpend = int'(bus_cycles);
                end
            end else if (m_bpend > 1) m_bpend--;
            else begin m_bact = 0; m_bpend = 0; end

            sclr = 0; fdone = 0; ddone = 0;
            case (m_ph)
                0: case (m_pick())
                       2: if (m_slen == 1) sclr = 1;
                          else if (m_slen != 0) begin m_cnt = m_slen - 1; m_ph = 1; end
                       3: m_ph = 2;
                       4: m_ph = 3;
                       5: m_ph = 4;
                       default: ;
                   endcase
                1: if (m_cnt == 1) begin sclr = 1; m_ph = 0; end else m_cnt--;
                2: if (fill_done) begin fdone = 1; m_ph = 0; end
                3: if (dma_done) begin ddone = 1; m_ph = 0; end
                4: m_ph = 5;
                default: if (exec_done) m_ph = 0;
            endcase
            m_lock = m_lock | lock_set;
            m_halt = m_halt | halt_set;
            if (susp_set && !m_sen) begin m_sen = 1; m_slen = int'(susp_cycles); end
            else if (sclr) begin m_sen = 0; m_slen = 0; end
            m_fill = fill_set | (m_fill & !fdone);
            m_dma  = dma_set  | (m_dma & !ddone);
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        bit efin;
        if (rst_n && !finished) begin
            efin = m_bact && (m_bpend <= 1);
            chk(int'(grant) == m_grant(), "R2 grant", int'(grant), m_grant());
            chk(fill_start == (m_ph == 0 && m_pick() == 3), "R6 fill_start", fill_start, (m_ph == 0 && m_pick() == 3));
            chk(dma_start == (m_ph == 0 && m_pick() == 4), "R6 dma_start", dma_start, (m_ph == 0 && m_pick() == 4));
            chk(exec_start == (m_ph == 4), "R7 exec_start", exec_start, (m_ph == 4));
            chk(mem_rd == (efin && !m_bwr), "R8 mem_rd", mem_rd, (efin && !m_bwr));
            chk(mem_wr == (efin && m_bwr), "R8 mem_wr", mem_wr, (efin && m_bwr));
            if (efin) chk(int'(mem_addr) == m_baddr, "R8 mem_addr", int'(mem_addr), m_baddr);
            chk(int'(mdr) == m_mdr, "R9 mdr", int'(mdr), m_mdr);
            chk(int'(mem_wdata) == m_mdr, "R9 mem_wdata", int'(mem_wdata), m_mdr);
            chk(busy == (m_fill | m_dma | m_bact), "R10 busy", busy, (m_fill | m_dma | m_bact));
            chk(running == (m_fill | m_dma | m_bact | !m_halt), "R10 running", running,
                (m_fill | m_dma | m_bact | !m_halt));
        end
    end

    // ---------------- responders for the external units ----------------
    int lat_f = 2, lat_d = 2, lat_e = 2;
    int fcnt = 0, dcnt = 0, ecnt = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            fcnt = 0; dcnt = 0; ecnt = 0;
            r_fill_done = 0; r_dma_done = 0; r_exec_done = 0;
        end else begin
            r_fill_done = 0; r_dma_done = 0; r_exec_done = 0;
            if (fill_start) fcnt = lat_f;
            else if (fcnt > 0) begin fcnt--; r_fill_done = (fcnt == 0); end
            if (dma_start) dcnt = lat_d;
            else if (dcnt > 0) begin dcnt--; r_dma_done = (dcnt == 0); end
            if (exec_start) ecnt = lat_e;
            else if (ecnt > 0) begin ecnt--; r_exec_done = (ecnt == 0); end
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        step(3);
        rst_n = 1;
        chk(grant == 3'd5, "R1 reset grant", grant, 5);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(running == 1'b1, "R1 reset running", running, 1);
        chk(mdr == '0, "R1 reset mdr", int'(mdr), 0);
        chk(!(mem_rd || mem_wr), "R1 reset strobes", mem_rd | mem_wr, 0);
    endtask

    task automatic launch(input bit wr, input int addr, input int cycles);
        @(negedge clk);
        bus_launch = 1; bus_write = wr; bus_addr = AW'(addr); bus_cycles = PW'(cycles);
        @(negedge clk);
        bus_launch = 0;
    endtask

    initial begin
        int cnt, rd_n, wr_n;
        bit did, seen;
        int first;

        do_reset();
        step(10);

        // R8 / R9: deferred read then deferred write
        launch(0, 24'h001234, 3);
        step(6);
        chk(mdr == 16'h4808, "R9 read into mdr", int'(mdr), 16'h4808);
        @(negedge clk); mdr_load = 1; mdr_din = 16'hBEEF;
        @(negedge clk); mdr_load = 0;
        launch(1, 24'h00ABCD, 2);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            if (mem_wr && !seen) begin
                seen = 1;
                chk(mem_addr == 24'h00ABCD, "R9 write address", int'(mem_addr), 24'h00ABCD);
                chk(mem_wdata == 16'hBEEF, "R9 write data", int'(mem_wdata), 16'hBEEF);
            end
            @(negedge clk);
        end
        chk(seen, "R8 write strobe seen", seen, 1);

        // R8: second launch while one is outstanding is dropped
        @(negedge clk); bus_launch = 1; bus_write = 0; bus_addr = 24'h000100; bus_cycles = 8'd4;
        @(negedge clk); bus_write = 1; bus_addr = 24'h000200; bus_cycles = 8'd1;
        @(negedge clk); bus_launch = 0;
        rd_n = 0; wr_n = 0;
        for (int i = 0; i < 12; i++) begin
            if (mem_rd) rd_n++;
            if (mem_wr) wr_n++;
            @(negedge clk);
        end
        chk(rd_n == 1, "R8 one read strobe", rd_n, 1);
        chk(wr_n == 0, "R8 ignored launch", wr_n, 0);

        // R2: fill ranks above DMA
        lat_f = 2; lat_d = 2; lat_e = 1;
        @(negedge clk); fill_set = 1; dma_set = 1;
        @(negedge clk); fill_set = 0; dma_set = 0;
        first = -1;
        for (int i = 0; i < 30; i++) begin
            if (first < 0 && fill_start) first = 3;
            if (first < 0 && dma_start) first = 4;
            @(negedge clk);
        end
        chk(first == 3, "R2 fill before dma", first, 3);

        // R6: stray fill done during a DMA transfer is ignored
        lat_d = 5;
        @(negedge clk); dma_set = 1;
        @(negedge clk); dma_set = 0;
        for (int i = 0; i < 20 && grant != 3'd4; i++) @(negedge clk);
        fill_set = 1; spur_fill = 1;
        @(negedge clk); fill_set = 0; spur_fill = 0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (fill_start) seen = 1;
            @(negedge clk);
        end
        chk(seen, "R6 fill survives stray done", seen, 1);

        // R5: timed suspend of 5, second load ignored
        lat_e = 2;
        @(negedge clk); susp_cycles = 8'd5; susp_set = 1;
        cnt = 0; did = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            susp_set = 0;
            if (grant == 3'd2) cnt++;
            if (cnt == 2 && !did) begin did = 1; susp_cycles = 8'd40; susp_set = 1; end
        end
        susp_set = 0;
        chk(cnt == 5, "R5 suspend length 5", cnt, 5);

        @(negedge clk); susp_cycles = 8'd1; susp_set = 1;
        cnt = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            susp_set = 0;
            if (grant == 3'd2) cnt++;
        end
        chk(cnt == 1, "R5 suspend length 1", cnt, 1);

        // R3 / R10: halt idles and drops running
        @(negedge clk); halt_set = 1;
        @(negedge clk); halt_set = 0;
        step(12);
        chk(grant == 3'd0, "R3 halt idles", grant, 0);
        chk(running == 1'b0, "R10 halted not running", running, 0);
        step(20);
        chk(grant == 3'd0, "R3 halt sticky", grant, 0);
        lat_d = 4;
        @(negedge clk); dma_set = 1;
        @(negedge clk); dma_set = 0;
        chk(busy == 1'b1, "R10 busy on dma", busy, 1);
        chk(running == 1'b1, "R10 running while busy", running, 1);
        step(15);
        chk(grant == 3'd0, "R3 back to halt", grant, 0);

        // R2 / R3: lock over halt, and sticky
        @(negedge clk); lock_set = 1;
        @(negedge clk); lock_set = 0;
        step(2);
        chk(grant == 3'd1, "R2 lock over halt", grant, 1);
        @(negedge clk); fill_set = 1;
        @(negedge clk); fill_set = 0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            if (fill_start) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R2 fill blocked by lock", seen, 0);
        chk(busy == 1'b1, "R10 pending fill busy", busy, 1);
        chk(grant == 3'd1, "R3 lock sticky", grant, 1);

        // R1: reset clears the sticky flags
        do_reset();
        step(5);

        // R4: endless suspend blocks lower ranks; lock still wins
        @(negedge clk); susp_cycles = 8'd0; susp_set = 1;
        @(negedge clk); susp_set = 0;
        step(40);
        chk(grant == 3'd2, "R4 endless suspend", grant, 2);
        @(negedge clk); dma_set = 1;
        @(negedge clk); dma_set = 0;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (dma_start) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R4 dma held off", seen, 0);
        chk(grant == 3'd2, "R4 still suspended", grant, 2);
        @(negedge clk); lock_set = 1;
        @(negedge clk); lock_set = 0;
        step(2);
        chk(grant == 3'd1, "R2 lock over suspend", grant, 1);

        step(4);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule